// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Engine

This block is the timing core of a master on a single open-drain, bit-serial bus that runs at standard speed. A host issues one command at a time: a bus reset with a presence check, a single write bit, a single read bit, or a whole byte written or read. The engine turns each command into one or more time slots. It pulls the line low through a drive-enable output and reads the line back through a two-flop synchronizer. All slot timing comes from one parameter, the system clock frequency. Each microsecond target is turned into a number of clock cycles.

Every phase sits at a fixed target inside its legal window. The reset pulse is 500 µs low and is followed by a 480 µs release period. Presence is sampled 70 µs after the line is released. A write-0 slot is 65 µs low and a write-1 slot is 6 µs low. A read slot is 6 µs low and samples the line 13 µs after the falling edge. Every data slot lasts 70 µs, and the line is released for at least 5 µs before the next slot starts. Byte commands run eight slots in a row, least significant bit first. `busy` stays high from the cycle after a command is accepted until the final slot ends. `result` is updated in the same cycle that `busy` falls.

Top module: `owbus_master`

## Requirements
- R1: A reset command (code 0) drives the line low for exactly the cycle count of 500 µs, which lies inside the 480 to 640 µs window.
- R2: During a reset command the line is sampled 70 µs after it is released, seen through the two-flop synchronizer. `result` becomes 8'h01 if the line was low at that point and 8'h00 if it was high.
- R3: A reset command keeps `busy` high for 980 µs in total: 500 µs low plus 480 µs released.
- R4: A write-0 slot (a write with data bit 0) drives the line low for 65 µs.
- R5: A write-1 slot drives the line low for 6 µs.
- R6: Every write or read slot lasts 70 µs, so a single-bit command keeps `busy` high for 70 µs. The line is released for at least 5 µs between consecutive slots.
- R7: A read-bit command (code 2) drives the line low for 6 µs and samples the line 13 µs after the falling edge. `result` becomes {7'b0, line level}.
- R8: A write-byte command (code 3) or read-byte command (code 4) runs eight 70 µs slots, least significant bit first, starting with `cmd_data[0]`. A read byte puts the first bit received into `result[0]`.
- R9: Write commands (code 1 with `cmd_data[0]` as the bit, and code 3) leave `result` unchanged.
- R10: A command presented while `busy` is high is ignored. Codes 5 to 7 are ignored at all times.
- R11: After reset `busy`, `bus_drive_low` and `result` are zero. A valid command with `busy` low is accepted on a rising edge, and `busy` is high from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, accepted when busy is low |
| cmd | input | 3 | 0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte |
| cmd_data | input | 8 | Bit (bit 0) or byte to write |
| busy | output | 1 | High while a command is running |
| result | output | 8 | Presence flag, read bit, or read byte |
| bus_drive_low | output | 1 | Enable for the open-drain pull-down on the line |
| bus_in | input | 1 | Raw line level |

## Verification
The bench runs with a 1 MHz clock, so one cycle equals one microsecond and every window can be counted in cycles. `busy` rises on the accepting edge and is first seen at the next falling clock edge. The bench counts `busy` and `bus_drive_low` cycles at falling edges until `busy` drops, and only then compares `result`. A bench slave model responds on the first drive-low cycle. It pulls the line low for 20 cycles for a read 0, or for a chosen interval after the reset release for presence. Because of the synchronizer, the presence sample looks at the line as it was 68 cycles after release, and the read sample looks at it as it was 11 cycles after the falling edge. The bench places its presence pulses to fall clearly on one side of that point or the other.

// File: rtl/owbm_pkg.sv
package owbm_pkg;
  typedef enum logic [2:0] {
    OP_RESET = 3'd0, OP_WBIT = 3'd1, OP_RBIT = 3'd2, OP_WBYTE = 3'd3, OP_RBYTE = 3'd4
  } op_e;

  typedef enum logic [1:0] {SL_RESET, SL_W0, SL_W1, SL_READ} slot_e;

  localparam int unsigned RST_LOW_US   = 500;
  localparam int unsigned RST_REL_US   = 480;
  localparam int unsigned PRES_SAMP_US = 70;
  localparam int unsigned W0_LOW_US    = 65;
  localparam int unsigned W1_LOW_US    = 6;
  localparam int unsigned RD_LOW_US    = 6;
  localparam int unsigned RD_SAMP_US   = 13;
  localparam int unsigned SLOT_US      = 70;
  localparam int unsigned RST_MAX_US   = 640;
  localparam int unsigned REC_MIN_US   = 5;

  function automatic int unsigned us_to_cyc(int unsigned us, int unsigned hz);
    longint unsigned prod;
    prod = longint'(us) * longint'(hz);
    return int'(prod / 64'd1_000_000);
  endfunction

  function automatic slot_e kind_of(op_e op, logic bit_val);
    case (op)
      OP_RESET:           return SL_RESET;
      OP_WBIT, OP_WBYTE:  return bit_val ? SL_W1 : SL_W0;
      default:            return SL_READ;
    endcase
  endfunction
endpackage

// File: rtl/owbm_sync.sv
module owbm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b1;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/owbm_slot.sv
module owbm_slot
  import owbm_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  slot_e kind_in,
  input  logic  line_q,
  output logic  active,
  output logic  drive_low,
  output logic  done,
  output logic  bit_q
);
  localparam int unsigned C_RST_LOW = us_to_cyc(RST_LOW_US, CLK_HZ);
  localparam int unsigned C_PSAMP   = us_to_cyc(RST_LOW_US + PRES_SAMP_US, CLK_HZ);
  localparam int unsigned C_RST_END = us_to_cyc(RST_LOW_US + RST_REL_US, CLK_HZ);
  localparam int unsigned C_W0_LOW  = us_to_cyc(W0_LOW_US, CLK_HZ);
  localparam int unsigned C_W1_LOW  = us_to_cyc(W1_LOW_US, CLK_HZ);
  localparam int unsigned C_RD_LOW  = us_to_cyc(RD_LOW_US, CLK_HZ);
  localparam int unsigned C_RD_SAMP = us_to_cyc(RD_SAMP_US, CLK_HZ);
  localparam int unsigned C_SLOT    = us_to_cyc(SLOT_US, CLK_HZ);
  localparam int CW = $clog2(C_RST_END + 1);

  slot_e kind;
  logic [CW-1:0] cnt, low_len, samp_at, end_at;

  always_comb begin
    case (kind)
      SL_RESET: begin low_len = CW'(C_RST_LOW); samp_at = CW'(C_PSAMP);   end_at = CW'(C_RST_END); end
      SL_W0:    begin low_len = CW'(C_W0_LOW);  samp_at = CW'(C_SLOT);    end_at = CW'(C_SLOT);    end
      SL_W1:    begin low_len = CW'(C_W1_LOW);  samp_at = CW'(C_SLOT);    end_at = CW'(C_SLOT);    end
      default:  begin low_len = CW'(C_RD_LOW);  samp_at = CW'(C_RD_SAMP); end_at = CW'(C_SLOT);    end
    endcase
  end

  assign done      = active && (cnt == end_at - CW'(1));
  assign drive_low = active && (cnt < low_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      kind   <= SL_W1;
      bit_q  <= 1'b0;
    end else begin
      if (active && cnt == samp_at)
        bit_q <= (kind == SL_RESET) ? ~line_q : line_q;
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        kind   <= kind_in;
      end else if (active) begin
        if (done) active <= 1'b0;
        else cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/owbm_seq.sv
module owbm_seq
  import owbm_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd,
  input  logic [BYTE_BITS-1:0] cmd_data,
  input  logic                 slot_done,
  input  logic                 slot_bit,
  output logic                 busy,
  output logic [BYTE_BITS-1:0] result,
  output logic                 slot_start,
  output slot_e                slot_kind
);
  localparam int LW = $clog2(BYTE_BITS);

  op_e                  op_q;
  logic [BYTE_BITS-1:0] shreg;
  logic [LW-1:0]        left;
  logic                 accept, last, is_read, is_byte_cmd;

  assign accept      = cmd_valid && !busy && (cmd <= 3'(OP_RBYTE));
  assign last        = (left == '0);
  assign is_read     = (op_q == OP_RBIT) || (op_q == OP_RBYTE) || (op_q == OP_RESET);
  assign is_byte_cmd = (cmd == 3'(OP_WBYTE)) || (cmd == 3'(OP_RBYTE));
  assign slot_start  = accept || (slot_done && !last);
  assign slot_kind   = accept ? kind_of(op_e'(cmd), cmd_data[0])
                              : kind_of(op_q, shreg[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      result <= '0;
      op_q   <= OP_RESET;
      shreg  <= '0;
      left   <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      op_q  <= op_e'(cmd);
      shreg <= cmd_data;
      left  <= is_byte_cmd ? LW'(BYTE_BITS-1) : '0;
    end else if (busy && slot_done) begin
      shreg <= {slot_bit, shreg[BYTE_BITS-1:1]};
      if (last) begin
        busy <= 1'b0;
        if (is_read)
          result <= (op_q == OP_RBYTE) ? {slot_bit, shreg[BYTE_BITS-1:1]}
                                       : {{(BYTE_BITS-1){1'b0}}, slot_bit};
      end else begin
        left <= left - LW'(1);
      end
    end
  end
endmodule

// File: rtl/owbus_master.sv
module owbus_master
  import owbm_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd,
  input  logic [7:0] cmd_data,
  output logic       busy,
  output logic [7:0] result,
  output logic       bus_drive_low,
  input  logic       bus_in
);
  logic  line_q, slot_start, slot_active, slot_done, slot_bit;
  slot_e slot_kind;

  owbm_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(line_q)
  );

  owbm_seq #(.BYTE_BITS(8)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .cmd_data(cmd_data), .slot_done(slot_done), .slot_bit(slot_bit),
    .busy(busy), .result(result), .slot_start(slot_start),
    .slot_kind(slot_kind)
  );

  owbm_slot #(.CLK_HZ(CLK_HZ)) u_slot (
    .clk(clk), .rst_n(rst_n), .start(slot_start), .kind_in(slot_kind),
    .line_q(line_q), .active(slot_active), .drive_low(bus_drive_low),
    .done(slot_done), .bit_q(slot_bit)
  );
endmodule

// File: rtl/owbm_checker.sv
module owbm_checker
  import owbm_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd,
  input logic       busy,
  input logic [7:0] result,
  input logic       drive_low,
  input logic       slot_start
);
  localparam int unsigned LOW_MAX = us_to_cyc(RST_MAX_US, CLK_HZ);
  localparam int unsigned REC_MIN = us_to_cyc(REC_MIN_US, CLK_HZ);

  int unsigned low_run, rel_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= 0;
      rel_run <= REC_MIN;
    end else begin
      low_run <= drive_low ? low_run + 1 : 0;
      if (drive_low) rel_run <= 0;
      else if (rel_run < REC_MIN) rel_run <= rel_run + 1;
    end
  end

  a_r1_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= LOW_MAX);
  a_r6_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> rel_run >= REC_MIN);
  a_r6_slot_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> $past(slot_start));
  a_r9_result_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(busy));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !drive_low);
  a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd <= 3'd4) |=> busy);
endmodule

bind owbus_master owbm_checker #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
  .busy(busy), .result(result), .drive_low(bus_drive_low),
  .slot_start(slot_start)
);

// File: tb/owbus_master_test.sv
module owbus_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned CLK_HZ = 1_000_000;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [7:0] cmd_data = 8'd0;
  logic busy, bus_drive_low, bus_in;
  logic [7:0] result;

  int errors = 0, checks = 0;

  // bench slave and monitor state
  logic slave_pull = 1'b0;
  logic prev_dl = 1'b0;
  int run = 0, np = 0, busy_cnt = 0, gap = 0, gap_min = 100000;
  int widths [0:15];
  logic rd_mode = 1'b0, pres_en = 1'b0;
  logic [7:0] slave_bits = 8'd0;
  int slave_idx = 0, pull_cnt = 0, pres_wait = 0, pres_hold = 0;
  int pres_delay = 30, pres_len = 120;

  assign bus_in = ~(bus_drive_low | slave_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  owbus_master #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .cmd_data(cmd_data), .busy(busy), .result(result),
    .bus_drive_low(bus_drive_low), .bus_in(bus_in)
  );

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (bus_drive_low) run++;
    if (busy && !bus_drive_low) gap++;
    if (bus_drive_low && !prev_dl) begin
      if (np > 0 && gap < gap_min) gap_min = gap;
      gap = 0;
      if (rd_mode) begin
        if (!slave_bits[slave_idx[2:0]]) pull_cnt = 20;
        slave_idx++;
      end
    end
    if (!bus_drive_low && prev_dl) begin
      if (np < 16) widths[np] = run;
      np++;
      if (pres_en && run >= 400) pres_wait = pres_delay;
      run = 0;
    end
    prev_dl = bus_drive_low;
    if (pull_cnt > 0) pull_cnt--;
    if (pres_hold > 0) pres_hold--;
    if (pres_wait > 0) begin
      pres_wait--;
      if (pres_wait == 0) pres_hold = pres_len;
    end
    slave_pull = (pull_cnt > 0) || (pres_hold > 0);
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic run_cmd(input logic [2:0] c, input logic [7:0] d);
    np = 0; busy_cnt = 0; gap = 0; gap_min = 100000; slave_idx = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R11 busy after accept", int'(busy), 1);
    while (busy) @(negedge clk);
    #1;
  endtask

  initial begin
    logic [7:0] prev_res;
    repeat (3) @(negedge clk);
    check("R11 reset busy", int'(busy), 0);
    check("R11 reset drive", int'(bus_drive_low), 0);
    check("R11 reset result", int'(result), 0);
    rst_n = 1'b1;

    // R1 R2 R3: reset with presence
    pres_en = 1'b1; pres_delay = 30; pres_len = 120;
    run_cmd(3'd0, 8'h00);
    check("R1 reset low width", widths[0], 500);
    check("R3 reset busy length", busy_cnt, 980);
    check("R2 presence seen", int'(result), 1);
    // presence pulse over before the sample point
    pres_delay = 15; pres_len = 45;
    run_cmd(3'd0, 8'h00);
    check("R2 early pulse absent", int'(result), 0);
    pres_delay = 60; pres_len = 60;
    run_cmd(3'd0, 8'h00);
    check("R2 late pulse present", int'(result), 1);
    pres_en = 1'b0;
    run_cmd(3'd0, 8'h00);
    check("R2 no slave", int'(result), 0);

    // R7 read bits
    rd_mode = 1'b1;
    slave_bits = 8'h00;
    run_cmd(3'd2, 8'h00);
    check("R7 read low width", widths[0], 6);
    check("R7 read zero", int'(result), 0);
    slave_bits = 8'hFF;
    run_cmd(3'd2, 8'h00);
    check("R7 read one", int'(result), 1);
    check("R6 read slot length", busy_cnt, 70);
    rd_mode = 1'b0;

    // R4 R5 R9 write bits
    prev_res = result;
    run_cmd(3'd1, 8'h00);
    check("R4 write0 low", widths[0], 65);
    check("R6 write0 slot", busy_cnt, 70);
    check("R9 result kept wbit0", int'(result), int'(prev_res));
    run_cmd(3'd1, 8'hFE);
    check("R4 write0 from bit0 only", widths[0], 65);
    run_cmd(3'd1, 8'h01);
    check("R5 write1 low", widths[0], 6);
    check("R6 write1 slot", busy_cnt, 70);
    check("R9 result kept wbit1", int'(result), int'(prev_res));

    // R8 write byte sweep
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v, got;
      v = 8'(i * 37 + 1);
      if (i == 7) v = 8'hFF;
      run_cmd(3'd3, v);
      got = 8'h00;
      for (int b = 0; b < 8; b++) got[b] = (widths[b] == 6);
      check("R8 write byte slots", np, 8);
      check("R8 write byte bits lsb first", int'(got), int'(v));
      check("R6 byte busy length", busy_cnt, 560);
      check("R6 recovery gap", int'(gap_min >= 5), 1);
      check("R9 result kept wbyte", int'(result), int'(prev_res));
    end

    // R8 read byte sweep
    rd_mode = 1'b1;
    for (int i = 0; i < 18; i++) begin
      logic [7:0] v;
      v = (i < 16) ? 8'(i * 17) : ((i == 16) ? 8'h01 : 8'h80);
      slave_bits = v;
      run_cmd(3'd4, 8'h00);
      check("R8 read byte value", int'(result), int'(v));
    end
    rd_mode = 1'b0;

    // R10 command while busy is ignored
    np = 0; busy_cnt = 0; gap_min = 100000;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = 3'd3; cmd_data = 8'h0F;
    @(negedge clk);
    cmd = 3'd0; cmd_data = 8'h00;
    repeat (100) @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    #1;
    check("R10 busy cmd ignored length", busy_cnt, 560);
    check("R10 busy cmd ignored slots", np, 8);
    // R10 unused codes
    for (int c = 5; c < 8; c++) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd = 3'(c);
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R10 unused code busy", int'(busy), 0);
      @(negedge clk);
      check("R10 unused code drive", int'(bus_drive_low), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule